// File: doc/BRIEF.md
# SPI Master Byte Shifter

This block is an 8-bit SPI master that exchanges one byte full-duplex each time software writes a transmit byte while the block is idle. It drives the serial clock and the serial data output, samples the serial data input, and places each received byte in a receive buffer. On completion it sets a buffer-full flag and pulses an interrupt request for one cycle. A write attempted during a transfer is dropped and noted in a sticky collision flag. A byte that completes while the buffer still holds an unread one is dropped and noted in a sticky overflow flag.

Run-time inputs choose the serial clock idle level and whether data is presented before the first clock edge or launched by it. They also choose whether input is sampled mid-bit or at the end of the bit, and where the bit rate comes from. The rate is one of three system-clock dividers, or an external timer tick that gives one serial-clock half-period per tick. A monitor input makes the master chain bytes back to back, sending all ones, so that a receive-only user can keep capturing the line.

Top module: `spi_byte_master`

## Requirements
- R1: A write (`wr_en`) while `busy` is low starts an exchange: `busy` is high from the next cycle, and `sdo` carries the written byte most significant bit first, bit k (counting from the MSB) held for half-periods 2k and 2k+1 of the 16 half-periods of the byte, starting in the cycle after the write.
- R2: `rate_sel` 0, 1 and 2 give half-periods of 2, 8 and 32 system clocks (dividers /4, /16, /64); `rate_sel` 3 ends a half-period at each cycle in which `tmr_tick` is high, so one serial clock period spans two ticks.
- R3: While `busy` is low, `sck` equals `cpol`, including right after a byte ends.
- R4: During half-period j of a byte, `sck` equals `cpol` XOR (j odd) when `early` is 1, and `cpol` XOR (j even) when `early` is 0, so with `early` = 0 the first edge coincides with the first data launch.
- R5: With `smp_end` = 0, `sdi` is sampled at the end of half-period 2k; with `smp_end` = 1 at the end of half-period 2k+1; the first sampled bit becomes the MSB of the received byte.
- R6: At the clock edge that ends half-period 15, `busy` falls (monitor off), `buf_full` rises, `rd_data` shows the received byte, and `irq` is high for exactly that one cycle.
- R7: A cycle with `rd_en` high and no byte completing clears `buf_full` from the next cycle.
- R8: A write while `busy` is high is ignored (the ongoing waveform and received byte are unchanged) and sets `wcol`; `clr_flags` clears `wcol` and `ovfl`.
- R9: If a byte completes while `buf_full` is set and `rd_en` is low, `ovfl` is set and `rd_data` keeps the older byte.
- R10: With `monitor` high at completion, `busy` stays high and a new byte starts at once, transmitting all ones (8'hFF), at the same rate and modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| early | input | 1 | 1: data valid before first edge; 0: first edge launches data |
| smp_end | input | 1 | 1: sample at end of bit; 0: mid-bit |
| rate_sel | input | 2 | Bit-rate source: 0 /4, 1 /16, 2 /64, 3 timer tick |
| tmr_tick | input | 1 | External timer pulse, one half-period per pulse |
| monitor | input | 1 | Chain bytes back to back sending all ones |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe, clears buffer-full |
| clr_flags | input | 1 | Clears collision and overflow flags |
| rd_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Unread byte in buffer |
| irq | output | 1 | One-cycle pulse per completed byte |
| busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Sticky write-collision flag |
| ovfl | output | 1 | Sticky overflow flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
With a divider of D, a write at edge E0 leaves `busy` high for 8·D cycles, and `buf_full`, `rd_data` and the `irq` pulse appear together after edge E(8·D). With the timer source, they appear after the edge that sees the sixteenth tick. The bench counts half-periods cycle by cycle from the write and drives inputs and samples outputs at the falling edge, so each half-period's `sck` and `sdo` are compared in the cycles they belong to. `sdi` carries different values in the two halves of each bit, so the received byte shows which sampling point was used. Flag results are read one cycle after their cause, and the `irq` low level one cycle after the pulse.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    RATE_DIV_A = 2'd0,
    RATE_DIV_B = 2'd1,
    RATE_DIV_C = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;

  // half-period length in system clocks for a divider
  function automatic int half_of(input int divider);
    return divider / 2;
  endfunction
endpackage

// File: rtl/spim_rate.sv
module spim_rate #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate_sel,
  input  logic       tmr_tick,
  output logic       half_tick
);
  import spim_pkg::*;

  localparam int MAXH = half_of(DIV_C);
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  rate_e         rsel;

  assign rsel = rate_e'(rate_sel);

  always_comb begin
    unique case (rsel)
      RATE_DIV_A: lim = CW'(half_of(DIV_A) - 1);
      RATE_DIV_B: lim = CW'(half_of(DIV_B) - 1);
      default:    lim = CW'(half_of(DIV_C) - 1);
    endcase
  end

  always_comb begin
    if (rsel == RATE_TMR) half_tick = run & tmr_tick;
    else                  half_tick = run && (cnt >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run)              cnt <= '0;
    else if (rsel != RATE_TMR)  cnt <= half_tick ? '0 : cnt + 1'b1;
  end

  // R2: a divider half-period is at least two clocks long
  p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && rsel != RATE_TMR) |=> (!half_tick || rsel == RATE_TMR));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_data,
  input  logic         half_tick,
  input  logic         cpol,
  input  logic         early,
  input  logic         smp_end,
  input  logic         monitor,
  input  logic         sdi,
  output logic         busy,
  output logic         sck,
  output logic         sdo,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int HALVES = 2 * W;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST = HW'(HALVES - 1);

  logic [HW-1:0] hcnt;
  logic [W-1:0]  tx_sr, rx_sr, rx_nxt;
  logic          take;

  assign take      = half_tick && (hcnt[0] == smp_end);
  assign byte_done = half_tick && (hcnt == LAST);

  always_comb begin
    rx_nxt = rx_sr;
    if (take) rx_nxt = {rx_sr[W-2:0], sdi};
  end

  assign rx_byte = rx_nxt;
  assign sdo     = tx_sr[W-1];
  assign sck     = busy ? (cpol ^ (early ? hcnt[0] : ~hcnt[0])) : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hcnt  <= '0;
      tx_sr <= '1;
      rx_sr <= '0;
    end else begin
      rx_sr <= rx_nxt;
      if (start && !busy) begin
        busy  <= 1'b1;
        hcnt  <= '0;
        tx_sr <= tx_data;
      end else if (half_tick) begin
        hcnt <= hcnt + 1'b1;
        if (hcnt[0]) tx_sr <= {tx_sr[W-2:0], 1'b1};
        if (byte_done) begin
          hcnt <= '0;
          if (monitor) tx_sr <= '1;
          else         busy  <= 1'b0;
        end
      end
    end
  end

  // R1: an exchange begins the cycle after an idle write
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && sdo == $past(tx_data[W-1])));
  // R3: serial clock rests at its idle level once a byte ends
  p_idle_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !monitor) |=> (sck == cpol || $changed(cpol)));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         early,
  input  logic         smp_end,
  input  logic [1:0]   rate_sel,
  input  logic         tmr_tick,
  input  logic         monitor,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         clr_flags,
  output logic [W-1:0] rd_data,
  output logic         buf_full,
  output logic         irq,
  output logic         busy,
  output logic         wcol,
  output logic         ovfl,
  output logic         sck,
  output logic         sdo,
  input  logic         sdi
);
  logic         half_tick;
  logic         byte_done;
  logic [W-1:0] rx_byte;

  spim_rate #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate_sel(rate_sel),
    .tmr_tick(tmr_tick), .half_tick(half_tick)
  );

  spim_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(wr_en), .tx_data(wr_data),
    .half_tick(half_tick), .cpol(cpol), .early(early), .smp_end(smp_end),
    .monitor(monitor), .sdi(sdi), .busy(busy), .sck(sck), .sdo(sdo),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      buf_full <= 1'b0;
      irq      <= 1'b0;
      wcol     <= 1'b0;
      ovfl     <= 1'b0;
    end else begin
      irq <= byte_done;
      if (clr_flags) begin
        wcol <= 1'b0;
        ovfl <= 1'b0;
      end
      if (wr_en && busy) wcol <= 1'b1;
      if (byte_done) begin
        buf_full <= 1'b1;
        if (buf_full && !rd_en) ovfl    <= 1'b1;
        else                    rd_data <= rx_byte;
      end else if (rd_en) begin
        buf_full <= 1'b0;
      end
    end
  end

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_busy_fall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> buf_full);
  p_wcol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_done) |=> !buf_full);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && buf_full && !rd_en) |=> (ovfl && $stable(rd_data)));
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, early = 1'b1, smp_end = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic tmr_tick = 1'b0, monitor = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, clr_flags = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic buf_full, irq, busy, wcol, ovfl, sck, sdo;
  logic sdi = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .early(early), .smp_end(smp_end),
    .rate_sel(rate_sel), .tmr_tick(tmr_tick), .monitor(monitor),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .clr_flags(clr_flags),
    .rd_data(rd_data), .buf_full(buf_full), .irq(irq), .busy(busy),
    .wcol(wcol), .ovfl(ovfl), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  // [26] cpol [25] early [24] smp_end [23:16] tx [15:8] sdi first half [7:0] sdi second half
  localparam logic [26:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hC3},
    {1'b0, 1'b1, 1'b1, 8'h5A, 8'h3C, 8'hC3},
    {1'b1, 1'b1, 1'b0, 8'h81, 8'hF0, 8'h0F},
    {1'b1, 1'b0, 1'b1, 8'h7E, 8'h12, 8'hED},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'h96, 8'h69}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one byte from the current falling edge; ends at the falling edge
  // in the cycle after the completing edge. ok reports sck/sdo/busy per cycle.
  task automatic run_byte(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                          input int halfc, input bit use_tmr, input bit do_wr,
                          input bit collide, output bit ok);
    ok = 1'b1;
    if (do_wr) begin
      wr_data = tx; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
    for (int j = 0; j < 16; j++) begin
      for (int c = 0; c < halfc; c++) begin
        sdi = (j % 2 == 0) ? a[7 - j/2] : b[7 - j/2];
        tmr_tick = use_tmr && (c == halfc - 1);
        wr_en = collide && j == 5 && c == 0;
        if (collide) wr_data = ~tx;
        #0;
        if (sck !== (cpol ^ (early ? (j % 2 == 1) : (j % 2 == 0)))) ok = 1'b0;
        if (sdo !== tx[7 - j/2]) ok = 1'b0;
        if (busy !== 1'b1) ok = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    tmr_tick = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [7:0] exp_rx, first_rx;
    repeat (3) @(negedge clk);
    // reset state (R3, R6)
    chk(busy === 1'b0 && buf_full === 1'b0 && irq === 1'b0, "R6 reset busy/full/irq",
        {busy, buf_full, irq}, 0);
    chk(wcol === 1'b0 && ovfl === 1'b0, "R8 reset flags", {wcol, ovfl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck === 1'b0, "R3 idle sck cpol=0", sck, 0);
    cpol = 1'b1; #0;
    chk(sck === 1'b1, "R3 idle sck cpol=1", sck, 1);

    // table of modes at /4 (R1 R4 R5 R6 R7)
    for (int v = 0; v < 6; v++) begin
      cpol = VEC[v][26]; early = VEC[v][25]; smp_end = VEC[v][24];
      exp_rx = smp_end ? VEC[v][7:0] : VEC[v][15:8];
      run_byte(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 2, 1'b0, 1'b1, 1'b0, ok);
      chk(ok, "R1/R4 waveform at /4", ok, 1);
      chk(busy === 1'b0 && buf_full === 1'b1 && irq === 1'b1, "R6 completion",
          {busy, buf_full, irq}, 3'b011);
      chk(rd_data === exp_rx, "R5 received byte", rd_data, exp_rx);
      chk(sck === cpol, "R3 idle after byte", sck, cpol);
      do_read();
      chk(irq === 1'b0 && buf_full === 1'b0, "R6/R7 irq pulse and read clear",
          {irq, buf_full}, 0);
    end

    // divider /16 and /64 (R2)
    cpol = 1'b0; early = 1'b1; smp_end = 1'b1;
    rate_sel = 2'd1;
    run_byte(8'hC6, 8'h00, 8'h5D, 8, 1'b0, 1'b1, 1'b0, ok);
    chk(ok && !busy && buf_full, "R2 /16 timing", {ok, busy, buf_full}, 3'b101);
    chk(rd_data === 8'h5D, "R2 /16 data", rd_data, 8'h5D);
    do_read();
    rate_sel = 2'd2;
    run_byte(8'h39, 8'hB2, 8'h00, 32, 1'b0, 1'b1, 1'b0, ok);
    chk(ok && !busy && buf_full, "R2 /64 timing", {ok, busy, buf_full}, 3'b101);
    do_read();

    // timer tick source, tick every third cycle (R2)
    rate_sel = 2'd3; early = 1'b0; smp_end = 1'b0;
    run_byte(8'h4B, 8'hE1, 8'h1E, 3, 1'b1, 1'b1, 1'b0, ok);
    chk(ok && !busy && buf_full, "R2 timer timing", {ok, busy, buf_full}, 3'b101);
    chk(rd_data === 8'hE1, "R2 timer data", rd_data, 8'hE1);
    do_read();

    // collision (R8)
    rate_sel = 2'd0; early = 1'b1;
    run_byte(8'h6D, 8'h2A, 8'hD5, 2, 1'b0, 1'b1, 1'b1, ok);
    chk(ok, "R8 waveform unchanged by busy write", ok, 1);
    chk(rd_data === 8'h2A, "R8 byte unchanged", rd_data, 8'h2A);
    chk(wcol === 1'b1, "R8 wcol set", wcol, 1);
    do_read();
    clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
    chk(wcol === 1'b0, "R8 wcol cleared", wcol, 0);

    // monitor chaining then overflow (R10 R9)
    monitor = 1'b1;
    run_byte(8'h93, 8'h47, 8'h00, 2, 1'b0, 1'b1, 1'b0, ok);
    first_rx = 8'h47;
    chk(ok && busy === 1'b1 && buf_full === 1'b1 && irq === 1'b1, "R10 busy holds",
        {ok, busy, buf_full, irq}, 4'b1111);
    monitor = 1'b0;
    run_byte(8'hFF, 8'hA8, 8'h00, 2, 1'b0, 1'b0, 1'b0, ok);
    chk(ok, "R10 chained byte sends all ones", ok, 1);
    chk(busy === 1'b0 && ovfl === 1'b1, "R9 overflow set", {busy, ovfl}, 1);
    chk(rd_data === first_rx, "R9 buffer keeps older byte", rd_data, first_rx);
    do_read();
    clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
    chk(ovfl === 1'b0 && buf_full === 1'b0, "R8 ovfl cleared", {ovfl, buf_full}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule